// File: doc/BRIEF.md
# Interrupt-Sensing GPIO Port

A 32-pin general-purpose I/O port that sits behind a plain 32-bit register bus. The bus has a word address, a write strobe, write data and read data. Software sets output values and pin directions and reads back the sampled input levels. Each pin also carries its own event detector. The detector can fire on a low level, a high level, a rising edge or a falling edge. A per-pin override makes it fire on any transition in either direction.

Detected events latch into a status register, which software clears by writing ones to it. The status register is ANDed with a mask. The result is reduced to two interrupt lines, one for the lower sixteen pins and one for the upper sixteen. Each pin input passes through a two-stage synchronizer. Edge detection compares the synchronized level with its value one cycle earlier. A change on a pad therefore reaches the status register on the third rising clock edge after it is applied.

Top module: `gpio_sense_port`

## Requirements
- R1: Registers decode on bus_addr[4:2] when bus_addr[1:0] is 0, with these word offsets: 0x00 output data, 0x04 direction, 0x08 pad level (read-only, writes ignored), 0x0C sense configuration for pins 0..15, 0x10 sense configuration for pins 16..31, 0x14 mask, 0x18 status, 0x1C any-edge select. A misaligned address reads 0 and writes nothing.
- R2: Reading the output data register returns the value last written to it, not the pad levels. pad_out mirrors that register. pad_oe mirrors the direction register, where 1 means the pin drives and 0 means the pin is released.
- R3: The pad level register returns pad_in after two register stages. A pad change applied before clock edge N reads back after edge N+1.
- R4: Pin n takes its 2-bit sense code from bits [2*(n mod 16)+1 : 2*(n mod 16)]. The code comes from the configuration word at 0x0C when bit 4 of n is 0, and from the word at 0x10 otherwise.
- R5: Code 0 (low level) and code 1 (high level) set the pin's status bit on every cycle that the synchronized level matches the code.
- R6: Code 2 sets status on a 0-to-1 change of the synchronized level, and code 3 sets it on a 1-to-0 change. The status bit becomes visible after the third rising edge that follows the pad change.
- R7: When a pin's bit in the any-edge register is 1, the pin sets status on every transition in either direction, and its 2-bit code is ignored.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event and a clear of the same bit in the same cycle leave the bit set, so a level that stays active keeps the bit set.
- R9: irq_lo is the OR of (status AND mask) over pins 0..15, and irq_hi is the same over pins 16..31.
- R10: While reset is held, every register reads 0, pad_out and pad_oe are 0, and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Output values toward the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Interrupt for pins 0..15 |
| irq_hi | output | 1 | Interrupt for pins 16..31 |

## Verification
Most internal faults reach the ports within one to three cycles. A corrupted synchronizer or previous-level register causes a missing or extra status bit when the status register is next read, no later than three edges after the pad change. A wrong field select or code decode sets status on the wrong pin or the wrong polarity, and the readback shows it immediately. A fault in the clear-versus-event priority or in the mask reduction shows on irq_lo or irq_hi in the cycle after the offending write. The bench therefore compares every readable register and both interrupt lines against a cycle-accurate reference on every cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int REG_AW  = 5;
    localparam int FIELD_W = 2;

    typedef enum logic [2:0] {
        REG_DATA   = 3'd0,
        REG_DIR    = 3'd1,
        REG_PAD    = 3'd2,
        REG_CFG_LO = 3'd3,
        REG_CFG_HI = 3'd4,
        REG_MASK   = 3'd5,
        REG_STAT   = 3'd6,
        REG_ANY    = 3'd7
    } reg_sel_e;

    typedef enum logic [FIELD_W-1:0] {
        SENSE_LOW  = 2'd0,
        SENSE_HIGH = 2'd1,
        SENSE_RISE = 2'd2,
        SENSE_FALL = 2'd3
    } sense_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense
    import gpio_port_pkg::*;
(
    input  logic               cur,
    input  logic               prev,
    input  logic [FIELD_W-1:0] code,
    input  logic               any_edge,
    output logic               evt
);
    always_comb begin
        if (any_edge) begin
            evt = cur ^ prev;
        end else begin
            unique case (sense_e'(code))
                SENSE_LOW:  evt = ~cur;
                SENSE_HIGH: evt = cur;
                SENSE_RISE: evt = cur & ~prev;
                SENSE_FALL: evt = ~cur & prev;
                default:    evt = 1'b0;
            endcase
        end
        // R7
        any_quiet_chk: assert (!(any_edge && (cur == prev) && evt));
    end
endmodule

// File: rtl/gpio_sense_port.sv
module gpio_sense_port
    import gpio_port_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pad_in,
    output logic [DATA_W-1:0] pad_out,
    output logic [DATA_W-1:0] pad_oe,
    output logic              irq_lo,
    output logic              irq_hi
);
    localparam int NUM_PINS = DATA_W;
    localparam int HALF     = NUM_PINS / 2;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] dir;
        logic [DATA_W-1:0] cfg_lo;
        logic [DATA_W-1:0] cfg_hi;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] any_edge;
        logic [DATA_W-1:0] prev;
    } port_regs_t;

    port_regs_t        q, d;
    logic [DATA_W-1:0] level_sync;
    logic [DATA_W-1:0] evt;
    logic [DATA_W-1:0] clr;
    reg_sel_e          sel;
    logic              aligned;
    logic              wr_hit;

    assign sel     = reg_sel_e'(bus_addr[REG_AW-1:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_hit  = bus_we && aligned;

    gpio_in_sync #(.W(DATA_W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (level_sync)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int FPOS = FIELD_W * (p % HALF);
        logic [FIELD_W-1:0] code;
        if (p < HALF) begin : g_lo
            assign code = q.cfg_lo[FPOS +: FIELD_W];
        end else begin : g_hi
            assign code = q.cfg_hi[FPOS +: FIELD_W];
        end
        gpio_pin_sense u_sense (
            .cur      (level_sync[p]),
            .prev     (q.prev[p]),
            .code     (code),
            .any_edge (q.any_edge[p]),
            .evt      (evt[p])
        );
    end

    always_comb begin
        d   = q;
        clr = '0;
        if (wr_hit) begin
            unique case (sel)
                REG_DATA:   d.data     = bus_wdata;
                REG_DIR:    d.dir      = bus_wdata;
                REG_CFG_LO: d.cfg_lo   = bus_wdata;
                REG_CFG_HI: d.cfg_hi   = bus_wdata;
                REG_MASK:   d.mask     = bus_wdata;
                REG_STAT:   clr        = bus_wdata;
                REG_ANY:    d.any_edge = bus_wdata;
                default:    ;
            endcase
        end
        d.stat = (q.stat & ~clr) | evt;
        d.prev = level_sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (sel)
                REG_DATA:   bus_rdata = q.data;
                REG_DIR:    bus_rdata = q.dir;
                REG_PAD:    bus_rdata = level_sync;
                REG_CFG_LO: bus_rdata = q.cfg_lo;
                REG_CFG_HI: bus_rdata = q.cfg_hi;
                REG_MASK:   bus_rdata = q.mask;
                REG_STAT:   bus_rdata = q.stat;
                REG_ANY:    bus_rdata = q.any_edge;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign pad_out = q.data;
    assign pad_oe  = q.dir;
    assign irq_lo  = |(q.stat[HALF-1:0] & q.mask[HALF-1:0]);
    assign irq_hi  = |(q.stat[NUM_PINS-1:HALF] & q.mask[NUM_PINS-1:HALF]);

    // R8
    evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((q.stat & $past(evt)) == $past(evt)));

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && sel == REG_STAT) |=> ((q.stat & $past(bus_wdata & ~evt)) == '0));

    // R8
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.stat & ~$past(q.stat | evt)) == '0));

    // R9
    irq_lo_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> (q.mask[HALF-1:0] != '0));

    // R9
    irq_hi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> (q.mask[NUM_PINS-1:HALF] != '0));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && sel == REG_DIR) |=> (pad_oe == $past(bus_wdata)));
endmodule

// File: tb/test_gpio_sense_port.sv
module test_gpio_sense_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq_lo, irq_hi;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // reference state
    logic [31:0] m_data, m_dir, m_cfglo, m_cfghi, m_mask, m_stat, m_any;
    logic [31:0] m_prev, m_s1, m_s2;

    always #2 clk = ~clk;

    gpio_sense_port i_gpio_sense_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic model_reset();
        m_data = '0; m_dir = '0; m_cfglo = '0; m_cfghi = '0; m_mask = '0;
        m_stat = '0; m_any = '0; m_prev = '0; m_s1 = '0; m_s2 = '0;
    endtask

    function automatic logic [31:0] exp_rd(input logic [4:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a[4:2])
            3'd0: return m_data;
            3'd1: return m_dir;
            3'd2: return m_s2;
            3'd3: return m_cfglo;
            3'd4: return m_cfghi;
            3'd5: return m_mask;
            3'd6: return m_stat;
            default: return m_any;
        endcase
    endfunction

    function automatic logic [31:0] exp_evt();
        logic [31:0] ev;
        for (int i = 0; i < 32; i++) begin
            logic [1:0] c;
            c = (i < 16) ? m_cfglo[2*i +: 2] : m_cfghi[2*(i-16) +: 2];
            if (m_any[i])       ev[i] = m_s2[i] ^ m_prev[i];
            else if (c == 2'd0) ev[i] = ~m_s2[i];
            else if (c == 2'd1) ev[i] = m_s2[i];
            else if (c == 2'd2) ev[i] = m_s2[i] & ~m_prev[i];
            else                ev[i] = ~m_s2[i] & m_prev[i];
        end
        return ev;
    endfunction

    task automatic model_step();
        logic [31:0] ev, clr;
        ev  = exp_evt();
        clr = '0;
        if (bus_we && bus_addr[1:0] == 2'b00) begin
            case (bus_addr[4:2])
                3'd0: m_data  = bus_wdata;
                3'd1: m_dir   = bus_wdata;
                3'd3: m_cfglo = bus_wdata;
                3'd4: m_cfghi = bus_wdata;
                3'd5: m_mask  = bus_wdata;
                3'd6: clr     = bus_wdata;
                3'd7: m_any   = bus_wdata;
                default: ;
            endcase
        end
        m_stat = (m_stat & ~clr) | ev;
        m_prev = m_s2;
        m_s2   = m_s1;
        m_s1   = pad_in;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick(input string req, input logic we, input logic [4:0] a,
                        input logic [31:0] wd, input logic [31:0] pins);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = wd; pad_in = pins;
        #1;
        chk(req, "rdata", bus_rdata, exp_rd(a));
        chk("R9", "irq_lo", {31'b0, irq_lo}, {31'b0, |(m_stat[15:0] & m_mask[15:0])});
        chk("R9", "irq_hi", {31'b0, irq_hi}, {31'b0, |(m_stat[31:16] & m_mask[31:16])});
        chk("R2", "pad_out", pad_out, m_data);
        chk("R2", "pad_oe", pad_oe, m_dir);
        @(posedge clk);
        if (rst_n) model_step();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] pins;
        void'($urandom(32'd5151));
        model_reset();
        // R10: reset state of every register and output
        for (int r = 0; r < 8; r++) tick("R10", 1'b0, 5'(r * 4), 32'h0, 32'hFFFF_FFFF);
        chk("R10", "stat", m_stat, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        pins = 32'h0;

        // R2: data register reads back written value, not pads
        tick("R2", 1'b1, 5'h00, 32'hA5A5_5A5A, pins);
        tick("R2", 1'b1, 5'h04, 32'hFFFF_0000, pins);
        tick("R2", 1'b0, 5'h00, 32'h0, pins);
        // R1: pad register ignores writes, misaligned access reads zero
        tick("R1", 1'b1, 5'h08, 32'h1234_5678, pins);
        tick("R1", 1'b1, 5'h01, 32'hFFFF_FFFF, pins);
        tick("R1", 1'b0, 5'h01, 32'h0, pins);
        tick("R1", 1'b0, 5'h00, 32'h0, pins);
        // R3: pad level readback latency
        pins = 32'h1234_5678;
        for (int k = 0; k < 4; k++) tick("R3", 1'b0, 5'h08, 32'h0, pins);

        // R6: all pins rising, clear status, then a single pin rises
        tick("R4", 1'b1, 5'h0C, 32'hAAAA_AAAA, pins);
        tick("R4", 1'b1, 5'h10, 32'hAAAA_AAAA, pins);
        tick("R9", 1'b1, 5'h14, 32'hFFFF_FFFF, pins);
        pins = 32'h0;
        for (int k = 0; k < 4; k++) tick("R8", 1'b1, 5'h18, 32'hFFFF_FFFF, pins);
        pins = 32'h0010_0000;
        for (int k = 0; k < 5; k++) tick("R6", 1'b0, 5'h18, 32'h0, pins);
        chk("R6", "stat bit20", m_stat, 32'h0010_0000);
        // R8: write zero leaves status, write one clears
        tick("R8", 1'b1, 5'h18, 32'h0, pins);
        tick("R8", 1'b1, 5'h18, 32'h0010_0000, pins);
        tick("R8", 1'b0, 5'h18, 32'h0, pins);
        // R6: falling code on pin 4 only
        tick("R6", 1'b1, 5'h0C, 32'h0000_0300, pins);
        pins = 32'h0000_0010;
        for (int k = 0; k < 4; k++) tick("R6", 1'b0, 5'h18, 32'h0, pins);
        tick("R8", 1'b1, 5'h18, 32'hFFFF_FFFF, pins);
        pins = 32'h0;
        for (int k = 0; k < 5; k++) tick("R6", 1'b0, 5'h18, 32'h0, pins);

        // R5: high level on pin 3 and pin 19 stays set through clears
        tick("R5", 1'b1, 5'h0C, 32'h5555_5555, pins);
        tick("R5", 1'b1, 5'h10, 32'h5555_5555, pins);
        pins = 32'h0008_0008;
        for (int k = 0; k < 4; k++) tick("R5", 1'b1, 5'h18, 32'hFFFF_FFFF, pins);
        tick("R8", 1'b1, 5'h18, 32'h0008_0008, pins);
        tick("R8", 1'b0, 5'h18, 32'h0, pins);
        tick("R9", 1'b1, 5'h14, 32'h0000_FFFF, pins);
        tick("R9", 1'b1, 5'h14, 32'hFFFF_0000, pins);
        tick("R9", 1'b0, 5'h18, 32'h0, pins);

        // R7: any-edge overrides code on pin 5 (code says high level)
        tick("R7", 1'b1, 5'h1C, 32'h0000_0020, pins);
        pins = 32'h0;
        for (int k = 0; k < 4; k++) tick("R7", 1'b1, 5'h18, 32'hFFFF_FFFF, pins);
        pins = 32'h0000_0020;
        for (int k = 0; k < 4; k++) tick("R7", 1'b0, 5'h18, 32'h0, pins);
        // R8: clear in the same cycle as a fresh event on pin 5
        pins = 32'h0;
        tick("R8", 1'b0, 5'h18, 32'h0, pins);
        tick("R8", 1'b0, 5'h18, 32'h0, pins);
        tick("R8", 1'b1, 5'h18, 32'h0000_0020, pins);
        tick("R8", 1'b0, 5'h18, 32'h0, pins);
        chk("R8", "stat bit5 kept", m_stat & 32'h20, 32'h20);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic we;
            logic [4:0] a;
            logic [31:0] wd;
            we = ($urandom_range(0, 9) < 4);
            a  = 5'($urandom_range(0, 7) * 4);
            wd = $urandom();
            if (a == 5'h18 && $urandom_range(0, 1) == 0) wd = wd & $urandom();
            if ($urandom_range(0, 4) == 0) pins = pins ^ ($urandom() & $urandom());
            tick("R4", we, a, wd, pins);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule